// File: doc/BRIEF.md
# Selectable-Source Gated Clock Fanout

This block drives six clock outputs from one of two clock sources. The first source is the fast system clock. The second is a slower scan or test clock. A single select input picks the source, and every output follows the one that is selected. Diagnostics can therefore run on the slow clock over the same distribution path that carries the system clock.

Each output can be gated off. A common enable and six per-output enables, all active low, are sampled on the falling edge of whichever source is currently selected. The sampled value then gates that output until the next falling edge. An enable change can only start or stop an output at a point where the clock is already low. A high pulse is therefore never cut short, and a pulse is never started part way through a high phase. An active-high asynchronous reset clears the gating state so that all outputs are low.

Top module: `clkfan_top`

## Requirements
- R1: Each of the six outputs equals the selected source clock AND-ed with that output's enable state, as captured at the most recent falling edge of the selected source.
- R2: With useTest low (0), the outputs follow mainClk, and testClk has no effect on them.
- R3: With useTest high (1), the outputs follow testClk, and mainClk has no effect on them.
- R4: An enable change that happens between two falling edges of the selected source has no effect on any output until the next such falling edge. A change that is reverted before that edge has no effect at all.
- R5: Output i toggles only when commonEnN is 0 and chanEnN[i] is 0. Otherwise it is held at 0. commonEnN at 1 holds all six outputs at 0.
- R6: rst at 1 forces every output to 0 at once, without waiting for a clock edge. After rst returns to 0, the outputs stay at 0 until a falling edge of the selected source captures the enables.
- R7: Deasserting an enable while the selected clock is high does not shorten the current high pulse. No output ever has a high pulse shorter than half a period of the selected source.
- R8: Asserting an enable while the selected clock is high does not produce a partial pulse. The output stays at 0 for the rest of that high phase and first rises on the next rising edge.
- R9: Enables are captured only on falling edges of the selected source. While testClk is selected, a falling edge of mainClk does not change any output's enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mainClk | input | 1 | Fast system clock source |
| testClk | input | 1 | Slow scan/test clock source |
| useTest | input | 1 | Source select: 0 selects mainClk, 1 selects testClk |
| rst | input | 1 | Asynchronous reset, active high; clears all gating state |
| commonEnN | input | 1 | Common enable, active low |
| chanEnN | input | 6 | Per-output enables, active low, bit i for output i |
| clkOut | output | 6 | Gated clock outputs |

## Verification
Three kinds of enable change are driven in the high phase and in the low phase of the selected clock: a disable, an enable, and a pulse that is asserted and then reverted. These separate capture at the falling edge from level-sensitive gating, and that in turn from a design that truncates or starts a pulse mid-phase. Mixed per-output masks, together with toggling of the common enable, show whether each output is tied to its own enable bit and to the common one. The source is switched both ways. The outputs are then sampled while one source is high and the other is low, and an enable change is timed to fall on a falling edge of the unselected clock only. This shows which source drives the outputs and which source clocks the capture. A running model comparison and a pulse-width monitor on every output cover the whole run.

// File: rtl/clkfan_pkg.sv
`timescale 1ns/100ps
package clkfan_pkg;
  // number of gated clock outputs
  localparam int unsigned NUM_OUTS = 6;

  // strobes from the enable control to the gating datapath
  typedef struct packed {
    logic [NUM_OUTS-1:0] gateOn;
  } gate_t;
endpackage

// File: rtl/clkfan_mux.sv
`timescale 1ns/100ps
// Source selection: picks the clock that feeds the whole fanout.
module clkfan_mux (
  input  logic mainClk,
  input  logic testClk,
  input  logic useTest,
  output logic selClk
);
  always_comb begin
    if (useTest) selClk = testClk;
    else         selClk = mainClk;
  end
endmodule

// File: rtl/clkfan_ctrl.sv
`timescale 1ns/100ps
// Enable capture: active-low enables are combined and registered on the
// falling edge of the selected clock, so state only changes while it is low.
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter int unsigned NumOuts = NUM_OUTS
) (
  input  logic               selClk,
  input  logic               rst,
  input  logic               commonEnN,
  input  logic [NumOuts-1:0] chanEnN,
  output gate_t              gates
);
  logic [NumOuts-1:0] wantOn;
  logic [NumOuts-1:0] gateReg;

  always_comb begin
    wantOn = ~chanEnN & {NumOuts{~commonEnN}};
  end

  genvar i;
  generate
    for (i = 0; i < NumOuts; i++) begin : g_capture
      always_ff @(negedge selClk or posedge rst) begin
        if (rst) gateReg[i] <= 1'b0;
        else     gateReg[i] <= wantOn[i];
      end
    end
  endgenerate

  always_comb begin
    gates.gateOn = gateReg;
  end
endmodule

// File: rtl/clkfan_gate.sv
`timescale 1ns/100ps
// Output gating: each output is the selected clock qualified by its strobe.
module clkfan_gate
  import clkfan_pkg::*;
#(
  parameter int unsigned NumOuts = NUM_OUTS
) (
  input  logic               selClk,
  input  gate_t              gates,
  output logic [NumOuts-1:0] clkOut
);
  genvar i;
  generate
    for (i = 0; i < NumOuts; i++) begin : g_and
      always_comb begin
        clkOut[i] = selClk & gates.gateOn[i];
      end
    end
  endgenerate
endmodule

// File: rtl/clkfan_top.sv
`timescale 1ns/100ps
module clkfan_top
  import clkfan_pkg::*;
(
  input  logic                mainClk,
  input  logic                testClk,
  input  logic                useTest,
  input  logic                rst,
  input  logic                commonEnN,
  input  logic [NUM_OUTS-1:0] chanEnN,
  output logic [NUM_OUTS-1:0] clkOut
);
  logic  selClk;
  gate_t gates;

  clkfan_mux u_mux (
    .mainClk (mainClk),
    .testClk (testClk),
    .useTest (useTest),
    .selClk  (selClk)
  );

  clkfan_ctrl #(.NumOuts(NUM_OUTS)) u_ctrl (
    .selClk    (selClk),
    .rst       (rst),
    .commonEnN (commonEnN),
    .chanEnN   (chanEnN),
    .gates     (gates)
  );

  clkfan_gate #(.NumOuts(NUM_OUTS)) u_gate (
    .selClk (selClk),
    .gates  (gates),
    .clkOut (clkOut)
  );
endmodule

// File: rtl/clkfan_chk.sv
`timescale 1ns/100ps
module clkfan_chk
  import clkfan_pkg::*;
(
  input logic                mainClk,
  input logic                testClk,
  input logic                useTest,
  input logic                rst,
  input logic                commonEnN,
  input logic [NUM_OUTS-1:0] chanEnN,
  input logic                selClk,
  input logic [NUM_OUTS-1:0] clkOut
);
  logic [NUM_OUTS-1:0] wantEn;
  logic                seenFall;

  assign wantEn = ~chanEnN & {NUM_OUTS{~commonEnN}};

  // set once a falling edge of the selected clock has occurred since reset
  always_ff @(negedge selClk or posedge rst) begin
    if (rst) seenFall <= 1'b0;
    else     seenFall <= 1'b1;
  end

  // R1 R4 R5: just before a falling edge the outputs show what was captured at the previous one
  p_capture_r4: assert property (@(negedge selClk) disable iff (rst)
    seenFall |-> (clkOut == $past(wantEn)));

  // R6: held low throughout reset
  p_reset_low_r6: assert property (@(posedge mainClk)
    rst |-> (clkOut == '0));

  // R2: main selected -> all outputs low just before every main rising edge
  p_main_src_r2: assert property (@(posedge mainClk) disable iff (rst)
    !useTest |-> (clkOut == '0));

  // R3: test selected -> all outputs low just before every test rising edge
  p_test_src_r3: assert property (@(posedge testClk) disable iff (rst)
    useTest |-> (clkOut == '0));
endmodule

bind clkfan_top clkfan_chk u_chk (
  .mainClk   (mainClk),
  .testClk   (testClk),
  .useTest   (useTest),
  .rst       (rst),
  .commonEnN (commonEnN),
  .chanEnN   (chanEnN),
  .selClk    (selClk),
  .clkOut    (clkOut)
);

// File: tb/clkfan_top_test.sv
`timescale 1ns/100ps
module clkfan_top_test;
  localparam int N = 6;

  logic         mainClk = 1'b0;
  logic         testClk = 1'b0;
  logic         useTest = 1'b0;
  logic         rst     = 1'b1;
  logic         commonEnN = 1'b0;
  logic [N-1:0] chanEnN   = '0;
  logic [N-1:0] clkOut;

  int checks = 0;
  int fails  = 0;
  int mism   = 0;
  int shortCnt [N];
  real riseT [N];

  // 125 MHz main clock, 24 ns test clock; falling edges of test align with main
  always #4  mainClk = ~mainClk;
  always #12 testClk = ~testClk;

  clkfan_top uut (
    .mainClk   (mainClk),
    .testClk   (testClk),
    .useTest   (useTest),
    .rst       (rst),
    .commonEnN (commonEnN),
    .chanEnN   (chanEnN),
    .clkOut    (clkOut)
  );

  // independent model from the requirements
  logic         refClk;
  logic [N-1:0] refEn;
  assign refClk = useTest ? testClk : mainClk;
  always @(negedge refClk or posedge rst) begin
    if (rst) refEn <= '0;
    else     refEn <= ~chanEnN & {N{~commonEnN}};
  end

  // R1: compare with the model half way between edges
  initial begin
    #0.5;
    forever begin
      if (clkOut !== ({N{refClk}} & refEn)) mism++;
      #1;
    end
  end

  // R7: pulse width monitor
  for (genvar i = 0; i < N; i++) begin : g_pw
    initial begin
      shortCnt[i] = 0;
      riseT[i] = 0.0;
    end
    always @(posedge clkOut[i]) riseT[i] = $realtime;
    always @(negedge clkOut[i])
      if (!rst && ($realtime - riseT[i] < 3.99)) shortCnt[i]++;
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clkOut=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // switch source while both clocks are low
  task automatic switchSel(input logic v);
    @(negedge testClk);
    #2;
    useTest = v;
  endtask

  task automatic t_reset;
    @(posedge mainClk); #1;
    chk("R6 in reset", clkOut, '0);
    rst = 0;
    #1;
    chk("R6 after release, before falling edge", clkOut, '0);
    @(posedge mainClk); #1;
    chk("R6 enabled after first falling edge", clkOut, '1);
  endtask

  task automatic t_disable_mid;
    @(posedge mainClk); #1;
    chanEnN[0] = 1'b1;
    #1;
    chk("R7 pulse completes after disable", clkOut, 6'b111111);
    @(posedge mainClk); #1;
    chk("R7 disabled from next phase", clkOut, 6'b111110);
  endtask

  task automatic t_enable_mid;
    @(posedge mainClk); #1;
    chanEnN[0] = 1'b0;
    #1;
    chk("R8 no partial pulse on enable", clkOut, 6'b111110);
    @(posedge mainClk); #1;
    chk("R8 starts on next rising edge", clkOut, 6'b111111);
  endtask

  task automatic t_low_change;
    @(negedge mainClk); #1;
    chanEnN[2] = 1'b1;
    #2;
    chanEnN[2] = 1'b0;
    @(posedge mainClk); #1;
    chk("R4 reverted change ignored", clkOut, 6'b111111);
    @(negedge mainClk); #1;
    chanEnN[2] = 1'b1;
    @(posedge mainClk); #1;
    chk("R4 change waits for falling edge", clkOut, 6'b111111);
    @(posedge mainClk); #1;
    chk("R4 change taken at falling edge", clkOut, 6'b111011);
  endtask

  task automatic t_masks;
    @(posedge mainClk); #1;
    chanEnN = 6'b010110;
    @(posedge mainClk); #1;
    chk("R5 per-output mask", clkOut, 6'b101001);
    commonEnN = 1'b1;
    @(posedge mainClk); #1;
    chk("R5 common disable", clkOut, 6'b000000);
    chanEnN = 6'b000000;
    @(posedge mainClk); #1;
    chk("R5 common still off", clkOut, 6'b000000);
    commonEnN = 1'b0;
    @(posedge mainClk); #1;
    chk("R5 common re-enabled", clkOut, 6'b111111);
  endtask

  task automatic t_test_src;
    switchSel(1'b1);
    @(posedge testClk); #1;
    chk("R3 follows test clock high", clkOut, 6'b111111);
    chanEnN[3] = 1'b1;
    #4;
    chk("R3 R9 main low, main fall not captured", clkOut, 6'b111111);
    #4;
    chk("R9 still high in same test phase", clkOut, 6'b111111);
    @(posedge testClk); #1;
    chk("R9 captured on test falling edge", clkOut, 6'b110111);
  endtask

  task automatic t_main_src;
    switchSel(1'b0);
    @(posedge mainClk); #1;
    chk("R2 follows main clock high", clkOut, 6'b110111);
    @(posedge testClk); #5;
    chk("R2 test high, main low", clkOut, 6'b000000);
  endtask

  task automatic t_async_reset;
    chanEnN = '0;
    @(posedge mainClk); @(posedge mainClk); #1;
    rst = 1'b1;
    #0.5;
    chk("R6 asynchronous clear", clkOut, '0);
    @(negedge mainClk); #1;
    rst = 1'b0;
    @(posedge mainClk); #1;
    chk("R6 held until falling edge", clkOut, '0);
    @(posedge mainClk); #1;
    chk("R6 resumes after falling edge", clkOut, '1);
  endtask

  initial begin
    t_reset();
    t_disable_mid();
    t_enable_mid();
    t_low_change();
    t_masks();
    t_test_src();
    t_main_src();
    t_async_reset();
    repeat (4) @(posedge mainClk);
    #1;
    checks++;
    if (mism != 0) begin
      fails++;
      $display("FAIL R1: %0d model mismatches, expected 0", mism);
    end
    begin
      int tot;
      tot = 0;
      for (int i = 0; i < N; i++) tot += shortCnt[i];
      checks++;
      if (tot != 0) begin
        fails++;
        $display("FAIL R7: %0d short pulses, expected 0", tot);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule